// File: doc/BRIEF.md
# One-Time-Programmable Word Store Mode Controller

This block is a synthesizable logical model of a UV-erasable, electrically programmable word memory. A small set of active-low control pins and a flag that stands in for the programming supply rail are decoded into six operating modes:

- **Read** (`MODE_READ`): the stored word at `addr` is driven out.
- **Output disable** (`MODE_OUTDIS`): the part is selected but the bus is released.
- **Standby** (`MODE_STANDBY`): the part is deselected.
- **Program** (`MODE_PROGRAM`): a strobe pulse writes a word.
- **Program verify** (`MODE_VERIFY`): the stored word is driven out while the programming supply is present.
- **Program inhibit** (`MODE_INHIBIT`): the programming supply is present but the part is deselected, so a strobe pulse writes nothing.

The data bus is modelled as separate `data_in` / `data_out` ports plus a drive flag `data_oe`. Analog levels and access timing are not modelled; only their logical effect is.

Programming can only clear bits. The stored word becomes the bitwise AND of the old word and the presented word. Only the `erase` input returns every word to all ones, and reset leaves the array in that erased state.

A write is committed by a three-state strobe machine:

- **`STB_IDLE`**: no pulse is in progress. It moves to `STB_PULSE` when the strobe is sampled low in program mode.
- **`STB_PULSE`**: a pulse is in progress. It returns to `STB_IDLE` and commits the write when the strobe is sampled high while still in program mode. It moves to `STB_ABORT` if the mode changes while the strobe is still low. If the mode changes on the same edge the strobe returns high, it goes back to `STB_IDLE` without writing.
- **`STB_ABORT`**: an abandoned pulse. It returns to `STB_IDLE` once the strobe is high, without writing.

`mode_o` reports the decoded mode as a 3-bit code.

Top module: `otp_word_store`

## Requirements
- R1: The mode code (`mode_o`) follows the pins as below. The strobe never affects the mode.

  | Supply flag | `ce_n` | `oe_n` | `mode_o` | Mode |
  |---|---|---|---|---|
  | absent | 0 | 0 | 0 | read |
  | absent | 0 | 1 | 1 | output disable |
  | absent | 1 | any | 2 | standby |
  | present | 0 | 1 | 3 | program |
  | present | 0 | 0 | 4 | verify |
  | present | 1 | any | 5 | program inhibit |

- R2: `data_oe` is 1 only in read (0) and verify (4). In every other mode `data_oe` is 0 and `data_out` is all zeros, whatever `oe_n` is.
- R3: In read and verify, `data_out` equals the word stored at `addr`, combinationally.
- R4: After reset, and after any clock edge at which `erase` is 1, every word reads 0xFFFF.
- R5: A committed write at address A with word D leaves the stored value at A equal to old AND D. No other address changes.
- R6: A write is committed at the first clock edge at which the strobe is sampled high after having been sampled low, with program mode held throughout. `addr` and `data_in` are taken at that edge.
- R7: A strobe held low for any number of cycles commits nothing until it is released.
- R8: Strobe pulses in program inhibit (mode 5) or in any mode other than program commit nothing.
- R9: If the mode leaves program while the strobe is low, that pulse is abandoned and no write occurs when the strobe rises.
- R10: An erase at the same edge as a commit wins, and the array reads all ones afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset; the array is left erased |
| addr | input | ADDR_W | Word address for read, verify and write |
| data_in | input | DATA_W | Word presented for programming |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| hv_present | input | 1 | High programming voltage present |
| erase | input | 1 | Returns every word to all ones |
| data_out | output | DATA_W | Read data, zero when not driving |
| data_oe | output | 1 | Bus drive flag (0 = high impedance) |
| mode_o | output | 3 | Decoded mode code |

## Verification
The assertions take the control pins to be stable between clock edges and sampled only at rising edges. They also take the erase input to be a request that may coincide with a strobe release. The strobe-history check takes it that the strobe was sampled at least once after reset before a commit.

The stimulus changes every input on the falling clock edge only. It keeps the strobe high during the mode sweeps, so that no stray pulse reaches the state machine. Pulses are opened and closed only inside the program and inhibit sequences that deliberately test them.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_OUTDIS  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5
    } otp_mode_e;

    typedef enum logic [1:0] {
        STB_IDLE  = 2'd0,
        STB_PULSE = 2'd1,
        STB_ABORT = 2'd2
    } stb_state_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      hv_present,
    output otp_mode_e mode,
    output logic      drive_en
);

    always_comb begin
        mode = MODE_STANDBY;
        unique case ({hv_present, ce_n, oe_n})
            3'b000:  mode = MODE_READ;
            3'b001:  mode = MODE_OUTDIS;
            3'b010,
            3'b011:  mode = MODE_STANDBY;
            3'b100:  mode = MODE_VERIFY;
            3'b101:  mode = MODE_PROGRAM;
            3'b110,
            3'b111:  mode = MODE_INHIBIT;
            default: mode = MODE_STANDBY;
        endcase
    end

    always_comb begin
        drive_en = 1'b0;
        unique case (mode)
            MODE_READ,
            MODE_VERIFY: drive_en = 1'b1;
            default:     drive_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/otp_strobe_fsm.sv
module otp_strobe_fsm
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  otp_mode_e mode,
    input  logic      pgm_n,
    output logic      wr_en
);

    stb_state_e state_q;
    stb_state_e state_d;
    logic       in_prog;

    assign in_prog = (mode == MODE_PROGRAM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_IDLE: begin
                if (in_prog && !pgm_n) begin
                    state_d = STB_PULSE;
                end
            end
            STB_PULSE: begin
                if (pgm_n) begin
                    state_d = STB_IDLE;
                end else if (!in_prog) begin
                    state_d = STB_ABORT;
                end
            end
            STB_ABORT: begin
                if (pgm_n) begin
                    state_d = STB_IDLE;
                end
            end
            default: state_d = STB_IDLE;
        endcase
    end

    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            STB_PULSE: wr_en = pgm_n && in_prog;
            default:   wr_en = 1'b0;
        endcase
    end

    // R6
    commit_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(!pgm_n) && pgm_n))
        else $error("commit without a sampled low strobe");

    // R8
    inhibit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PROGRAM) |-> !wr_en)
        else $error("write outside program mode");

endmodule

// File: rtl/otp_word_array.sv
module otp_word_array #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word_chk
        // R5
        only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !erase |=> ((mem[g] & ~$past(mem[g])) == '0))
            else $error("bit set without erase");

        // R4
        erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            erase |=> (mem[g] == '1))
            else $error("word not all ones after erase");
    end

endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
    import otp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORDS  = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              hv_present,
    input  logic              erase,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [2:0]        mode_o
);

    otp_mode_e         mode;
    logic              drive_en;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;

    otp_mode_decode i_decode (
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .hv_present (hv_present),
        .mode       (mode),
        .drive_en   (drive_en)
    );

    otp_strobe_fsm i_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .pgm_n (pgm_n),
        .wr_en (wr_en)
    );

    otp_word_array #(
        .WIDTH (DATA_W),
        .DEPTH (WORDS)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (data_in),
        .rd_addr (addr),
        .rd_data (rd_word)
    );

    always_comb begin
        data_oe  = drive_en;
        data_out = drive_en ? rd_word : '0;
        mode_o   = mode;
    end

    // R2
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!data_oe && data_out == '0))
        else $error("bus driven while deselected");

    // R2
    drive_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!ce_n && !oe_n))
        else $error("bus driven without both enables");

    // R1
    mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd5)
        else $error("mode code out of range");

endmodule

// File: tb/test_otp_word_store.sv
module test_otp_word_store;

    localparam int DW = 16;
    localparam int NW = 16;
    localparam int AW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          pgm_n = 1'b1;
    logic          hv_present = 1'b0;
    logic          erase = 1'b0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic [2:0]    mode_o;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] ref_mem [NW];

    always #5 clk = ~clk;

    otp_word_store #(.DATA_W(DW), .WORDS(NW)) i_otp_word_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .data_in    (data_in),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .pgm_n      (pgm_n),
        .hv_present (hv_present),
        .erase      (erase),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .mode_o     (mode_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req, input bit verify);
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            hv_present = verify; ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1;
            addr = AW'(a);
            #1;
            check(req, {15'd0, data_oe, data_out}, {15'd0, 1'b1, ref_mem[a]});
        end
    endtask

    task automatic program_word(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        hv_present = 1'b1; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b0;
        addr = AW'(a); data_in = d;
        @(negedge clk);
        pgm_n = 1'b1;
        @(negedge clk);
        ref_mem[a] = ref_mem[a] & d;
    endtask

    initial begin
        for (int a = 0; a < NW; a++) ref_mem[a] = '1;
        repeat (3) @(negedge clk);
        #1;
        check("R2 reset", {15'd0, data_oe, data_out}, 32'd0);
        rst_n = 1'b1;

        // R4: erased after reset, via read and verify
        read_all("R4 reset read", 1'b0);
        read_all("R4 reset verify", 1'b1);

        // R1 R2 R3: sweep all control combinations, strobe high
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            hv_present = c[2]; ce_n = c[1]; oe_n = c[0]; pgm_n = 1'b1;
            addr = AW'(c);
            #1;
            begin
                int em;
                bit eo;
                if (!c[2]) em = c[1] ? 2 : (c[0] ? 1 : 0);
                else       em = c[1] ? 5 : (c[0] ? 3 : 4);
                eo = !c[1] && !c[0];
                check("R1 mode", {29'd0, mode_o}, 32'(em));
                check("R2 drive", {31'd0, data_oe}, {31'd0, eo});
                check("R3 data", {16'd0, data_out}, {16'd0, eo ? ref_mem[c] : 16'h0});
            end
        end

        // R5 R6: two rounds of patterns into every word
        for (int a = 0; a < NW; a++) program_word(a, 16'(a * 16'h1111) ^ 16'hA5A5);
        read_all("R5 first round", 1'b0);
        for (int a = 0; a < NW; a++) program_word(a, ~16'(1 << a) & 16'h7FFF ^ 16'(a));
        read_all("R5 second round", 1'b1);

        // R7: strobe held low for many cycles
        @(negedge clk);
        hv_present = 1'b1; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b0;
        addr = AW'(3); data_in = 16'h0000;
        repeat (20) @(negedge clk);
        oe_n = 1'b0; #1;
        check("R7 held low", {16'd0, data_out}, {16'd0, ref_mem[3]});

        // R9: mode left program while low, then strobe released
        @(negedge clk);
        pgm_n = 1'b1;
        @(negedge clk);
        #1;
        check("R9 abort", {16'd0, data_out}, {16'd0, ref_mem[3]});

        // R8: pulses in inhibit mode
        @(negedge clk);
        hv_present = 1'b1; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b0;
        addr = AW'(5); data_in = 16'h0000;
        @(negedge clk); pgm_n = 1'b1;
        @(negedge clk); pgm_n = 1'b0;
        @(negedge clk); pgm_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; #1;
        check("R8 inhibit", {16'd0, data_out}, {16'd0, ref_mem[5]});

        // R8: pulse in output disable mode (supply absent)
        @(negedge clk);
        hv_present = 1'b0; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b0; addr = AW'(6);
        @(negedge clk); pgm_n = 1'b1;
        @(negedge clk); oe_n = 1'b0; #1;
        check("R8 outdis", {16'd0, data_out}, {16'd0, ref_mem[6]});

        // R10: erase on the commit edge
        @(negedge clk);
        hv_present = 1'b1; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b0;
        addr = AW'(7); data_in = 16'h0000;
        @(negedge clk);
        pgm_n = 1'b1; erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        for (int a = 0; a < NW; a++) ref_mem[a] = '1;
        read_all("R10 erase wins", 1'b0);

        // R4 R5: program after erase, then plain erase
        program_word(9, 16'h0F0F);
        read_all("R5 after erase", 1'b0);
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        for (int a = 0; a < NW; a++) ref_mem[a] = '1;
        read_all("R4 erase", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule